// File: doc/BRIEF.md
# Sliced Integer ALU with Stream Handshake

This block is a 32-bit integer arithmetic-logic unit. It is built from a chain of identical one-bit slices. Every slice holds an AND gate, an OR gate, a full adder and a four-way selector. A three-bit operation code picks bitwise AND, bitwise OR, addition, subtraction or signed set-on-less-than. Subtraction uses the same adder chain: operand b is inverted and the carry into bit 0 is forced high. Set-on-less-than runs that same subtraction. It takes the sign of the difference from the top slice, corrects it for signed overflow, and sends it back into bit 0. Only the lowest result bit can be set by this operation.

Operands enter through a valid/ready stream port. Results leave through a second valid/ready stream port after one register stage. An operand set is taken on any rising edge where `in_valid` and `in_ready` are both high. The output holds steady while `out_valid` is high and `out_ready` is low. The input side accepts a new operand set whenever the output register is empty or is being drained in that same cycle, so back-pressure passes straight to the source. A producer must keep its operands and code stable until they are accepted.

Top module: `alu_top`

## Requirements
- R1: Code 3'b000 gives `out_result = a & b`, with `out_ovf` = 0.
- R2: Code 3'b001 gives `out_result = a | b`, with `out_ovf` = 0.
- R3: Code 3'b010 gives `a + b` modulo 2^32. `out_ovf` = 1 exactly when both operands have the same sign and the sum has the opposite sign.
- R4: Code 3'b110 gives `a - b` modulo 2^32. `out_ovf` = 1 exactly when the operands differ in sign and the difference's sign differs from a's sign.
- R5: Code 3'b111 gives 1 in bit 0 when a < b as signed two's-complement numbers, and 0 otherwise. This holds even when the internal a − b overflows. Bits 31..1 are 0 and `out_ovf` = 0.
- R6: `out_zero` = 1 exactly when all 32 bits of `out_result` are 0.
- R7: The unused codes 3'b011, 3'b100 and 3'b101 give `out_result` = 0, `out_zero` = 1 and `out_ovf` = 0.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the output fields stay unchanged on the next edge.
- R9: While `rst_n` is low, and right after it rises, `out_valid` is 0 and the outputs read 0.
- R10: An operand set accepted on one edge appears on the outputs, with `out_valid` high, right after that edge. If nothing is accepted and `out_ready` is high, `out_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set can be taken this cycle |
| in_op | input | 3 | Operation code |
| in_a | input | 32 | Operand a |
| in_b | input | 32 | Operand b |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Selected result |
| out_zero | output | 1 | Result is all zeros |
| out_ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The data path holds no state, so a wrong carry, a missing b-inversion or a mis-steered less input shows up on the result port one cycle after the operand set is accepted. If the output register or its valid bit is wrong, the effect reaches the ports within one cycle. A result can be dropped, repeated or changed under back-pressure, and `in_ready` can disagree with the output occupancy. The comparison cases that matter most are those where a − b overflows. There the raw sign bit is wrong, and only the overflow correction gives the right set-on-less-than answer.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [2:0] OPC_AND = 3'b000;
  localparam logic [2:0] OPC_OR  = 3'b001;
  localparam logic [2:0] OPC_ADD = 3'b010;
  localparam logic [2:0] OPC_SUB = 3'b110;
  localparam logic [2:0] OPC_SLT = 3'b111;

  typedef enum logic [1:0] {
    PICK_AND  = 2'b00,
    PICK_OR   = 2'b01,
    PICK_SUM  = 2'b10,
    PICK_LESS = 2'b11
  } pick_e;

  function automatic logic opc_legal(input logic [2:0] opc);
    return (opc == OPC_AND) || (opc == OPC_OR) || (opc == OPC_ADD) ||
           (opc == OPC_SUB) || (opc == OPC_SLT);
  endfunction

  function automatic logic opc_arith(input logic [2:0] opc);
    return (opc == OPC_ADD) || (opc == OPC_SUB);
  endfunction
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic  a,
  input  logic  b,
  input  logic  b_flip,
  input  logic  cin,
  input  logic  less,
  input  pick_e pick,
  output logic  res,
  output logic  cout,
  output logic  set,
  output logic  ovf
);
  logic bx, sum;

  assign bx   = b ^ b_flip;
  assign sum  = a ^ bx ^ cin;
  assign cout = (a & bx) | (cin & (a ^ bx));

  always_comb begin
    unique case (pick)
      PICK_AND:  res = a & bx;
      PICK_OR:   res = a | bx;
      PICK_SUM:  res = sum;
      PICK_LESS: res = less;
      default:   res = 1'b0;
    endcase
  end

  generate
    if (IS_TOP) begin : g_top
      assign ovf = cin ^ cout;
      assign set = sum ^ (cin ^ cout);
    end else begin : g_plain
      assign ovf = 1'b0;
      assign set = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/alu_chain.sv
module alu_chain
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       opc,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             ovf
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] raw, less_v, set_v, ovf_v;
  logic             b_flip, set_w, ovf_raw;
  pick_e            pick;

  assign b_flip   = opc[2];
  assign pick     = pick_e'(opc[1:0]);
  assign carry[0] = b_flip;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == 0) begin : g_lsb_less
        assign less_v[i] = set_w;
      end else begin : g_zero_less
        assign less_v[i] = 1'b0;
      end
      alu_slice #(.IS_TOP(i == TOP)) u_slice (
        .a(a[i]), .b(b[i]), .b_flip(b_flip), .cin(carry[i]),
        .less(less_v[i]), .pick(pick), .res(raw[i]),
        .cout(carry[i+1]), .set(set_v[i]), .ovf(ovf_v[i])
      );
    end
  endgenerate

  assign set_w   = |set_v;
  assign ovf_raw = |ovf_v;

  assign result = opc_legal(opc) ? raw : '0;
  assign ovf    = opc_arith(opc) & ovf_raw;
  assign zero   = ~|result;
endmodule

// File: rtl/alu_top.sv
module alu_top
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic             out_zero,
  output logic             out_ovf
);
  logic [WIDTH-1:0] c_result;
  logic             c_zero, c_ovf, take;

  alu_chain #(.WIDTH(WIDTH)) u_chain (
    .a(in_a), .b(in_b), .opc(in_op),
    .result(c_result), .zero(c_zero), .ovf(c_ovf)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_zero   <= 1'b0;
      out_ovf    <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= c_result;
      out_zero   <= c_zero;
      out_ovf    <= c_ovf;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic             out_zero,
  input logic             out_ovf
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r1_and_value: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 3'b000) |=> (out_result == $past(in_a & in_b) && !out_ovf));

  a_r5_slt_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 3'b111) |=> (out_result[WIDTH-1:1] == '0 && !out_ovf));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_result == '0)));

  a_r7_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == 3'b011 || in_op == 3'b100 || in_op == 3'b101))
      |=> (out_result == '0 && out_zero && !out_ovf));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
                                   $stable(out_zero) && $stable(out_ovf)));

  a_r10_accept_visible: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
endmodule

bind alu_top alu_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .out_zero(out_zero),
  .out_ovf(out_ovf)
);

// File: tb/sim_alu_top.sv
`timescale 1ns/1ps
module sim_alu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'b000;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_zero;
  logic        out_ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  alu_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_zero(out_zero),
    .out_ovf(out_ovf)
  );

  // behavioural model state
  bit          m_valid = 1'b0;
  logic [31:0] m_res = '0;
  bit          m_ovf = 1'b0;
  logic [2:0]  m_op = 3'b000;

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b110:  return "R4";
      3'b111:  return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic model_op(input logic [31:0] a, input logic [31:0] b,
                          input logic [2:0] op,
                          output logic [31:0] r, output bit v);
    logic [31:0] s;
    v = 1'b0;
    case (op)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010: begin
        s = a + b; r = s;
        v = (a[31] == b[31]) && (s[31] != a[31]);
      end
      3'b110: begin
        s = a - b; r = s;
        v = (a[31] != b[31]) && (s[31] != a[31]);
      end
      3'b111: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: r = '0;
    endcase
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // directed corner vectors
  localparam int ND = 16;
  logic [31:0] d_a  [ND] = '{32'hF0F0_1234, 32'h0F0F_8421, 32'h7FFF_FFFF,
    32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678,
    32'h0000_0005, 32'hFFFF_FFFB, 32'h1111_1111, 32'hDEAD_BEEF, 32'hDEAD_BEEF,
    32'hDEAD_BEEF, 32'h8000_0000, 32'h0000_0000};
  logic [31:0] d_b  [ND] = '{32'h00FF_FF00, 32'hF000_000F, 32'h0000_0001,
    32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h1234_5678,
    32'h0000_0005, 32'h0000_0005, 32'h2222_2222, 32'h1234_5678, 32'h1234_5678,
    32'h1234_5678, 32'h8000_0000, 32'h0000_0000};
  logic [2:0]  d_op [ND] = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b010,
    3'b111, 3'b111, 3'b110, 3'b111, 3'b111, 3'b000, 3'b011, 3'b100,
    3'b101, 3'b010, 3'b001};

  localparam int NRAND = 4000;

  function automatic logic [31:0] pick_operand();
    case ($urandom_range(0, 5))
      0: return 32'h8000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0000;
      default: return $urandom();
    endcase
  endfunction

  initial begin : stim
    int   idx;
    bit   have;
    logic [31:0] r;
    bit   v;
    idx = 0;
    have = 1'b0;
    repeat (3) @(negedge clk);
    // R9: outputs during reset
    check(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
    check(out_result == '0, "R9", "out_result in reset", out_result, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    while (idx < ND + NRAND) begin
      // compare against model (state after last edge, inputs unchanged)
      check(out_valid == m_valid, "R10", "out_valid", out_valid, m_valid);
      check(in_ready == (!m_valid || out_ready), "R8", "in_ready",
            in_ready, (!m_valid || out_ready));
      if (m_valid) begin
        check(out_result == m_res, tag_of(m_op), "out_result", out_result, m_res);
        check(out_ovf == m_ovf, tag_of(m_op), "out_ovf", out_ovf, m_ovf);
        check(out_zero == (m_res == '0), "R6", "out_zero", out_zero, (m_res == '0));
      end
      // new inputs
      out_ready = (idx < ND) ? 1'b1 : ($urandom_range(0, 3) != 0);
      if (!have) begin
        if (idx < ND) begin
          in_a = d_a[idx]; in_b = d_b[idx]; in_op = d_op[idx]; have = 1'b1;
        end else if ($urandom_range(0, 7) != 0) begin
          in_a = pick_operand(); in_b = pick_operand();
          in_op = 3'($urandom_range(0, 7)); have = 1'b1;
        end
      end
      in_valid = have;
      // model update for the coming edge
      if (have && (!m_valid || out_ready)) begin
        model_op(in_a, in_b, in_op, r, v);
        m_valid = 1'b1; m_res = r; m_ovf = v; m_op = in_op;
        have = 1'b0;
        idx++;
      end else if (out_ready) begin
        m_valid = 1'b0;
      end
      @(negedge clk);
    end
    // R8 hold under back-pressure: result must not change
    in_valid = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == m_valid, "R8", "valid held", out_valid, m_valid);
    if (m_valid)
      check(out_result == m_res, "R8", "result held", out_result, m_res);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "drained", out_valid, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run hung actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule